// File: doc/BRIEF.md
# Line-Output Power Sequencer

This controller brings a codec's stereo line output up and takes it down again. Each transition is a fixed script of register writes, each an 8-bit address and 8-bit data. The writes go out over a valid/ready handshake to a downstream serial-bus master. A start request plays the bring-up script. The block first sets the sample rate, then the routing, the analog gain and the digital volume. It enters the amplifier power-save state, waits for the clock to lock, and powers the converter and the amplifiers. After the outputs have settled, it clears power-save, which enters normal playback.

A stop request plays the teardown script. Teardown runs in a different order from bring-up: power-save is entered first, then everything is powered down. The block then waits for the output pins to discharge, removes the routing, and only then leaves power-save. Both settling waits and the lock wait count a millisecond tick input, so the same block works at any system clock. Status outputs show when a script is running, when the line is playing, and when a script has just completed.

Top module: `lineout_pwr_seq`

## Requirements
- R1: After start, the bring-up writes (address←data, hex) are presented in exactly this order: 01←F4, 11←40, 1D←01, 15←05, 0D←01, 0E←01, 1A←28, 1B←28, 11←44, 00←C1, 11←47, 11←43. In register 11, bits 7:6 are the gain code (01), bit 2 is power-save and bits 1:0 enable the two amplifiers.
- R2: Between acceptance of 11←47 and presentation of 11←43, at least SETTLE_MS tick pulses occur. Only cycles with tick high advance the wait.
- R3: Between acceptance of 11←44 and presentation of 00←C1, at least LOCK_MS tick pulses occur.
- R4: After stop during playback, the teardown writes are presented in this order: 11←47, 00←01, 11←44, 0D←00, 0E←00, 11←40. At least SETTLE_MS ticks occur between acceptance of 11←44 and presentation of 0D←00.
- R5: While wr_valid is high and wr_ready is low, the address, the data and wr_valid hold steady. The script advances only on a cycle where both are high.
- R6: A stop request while idle produces no write. A start request while playing produces no write, and playing stays high.
- R7: A stop request that arrives during bring-up is remembered. The full bring-up completes, and then the teardown follows without a further request.
- R8: playing rises only after 11←43 has been accepted. It is low before the first teardown write is presented, and it is never high together with busy.
- R9: busy is high from the cycle after a start or stop is taken until the last write of its script is accepted. done pulses for exactly one cycle at the end of each script. No write is presented while busy is low.
- R10: A synchronous active-high reset returns the block to idle (busy, playing, done and wr_valid low) without presenting any further write. The next start begins again at 01←F4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| start_req | input | 1 | Request bring-up |
| stop_req | input | 1 | Request teardown |
| wr_ready | input | 1 | Downstream bus master accepts the write |
| wr_valid | output | 1 | Write presented |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 8 | Register data of the write |
| busy | output | 1 | A script is running |
| playing | output | 1 | Line output is in normal playback |
| done | output | 1 | One-cycle pulse when a script finishes |

## Verification
The bench stalls wr_ready on a regular pattern. A sequencer that advanced on valid alone, or changed the address during a stall, would skip or corrupt writes. The bench counts tick pulses only while no write is presented. A design that dropped or shortened the lock wait or either settle wait would show too few ticks before 00←C1, 11←43 or 0D←00. A stop issued in mid bring-up checks that the request is latched: a design that dropped it would stay in playback, and a design that acted on it at once would cut the bring-up short. Resetting partway through a script and starting again shows whether stale script position or a pending wait survives the reset.

// File: rtl/lops_pkg.sv
package lops_pkg;

  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    OP_WRITE,
    OP_WAIT_LOCK,
    OP_WAIT_SETTLE,
    OP_END
  } opKind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_UP,
    S_PLAY,
    S_DOWN
  } seqState_e;

  typedef struct packed {
    opKind_e          kind;
    logic [REG_W-1:0] addr;
    logic [REG_W-1:0] data;
  } step_t;

  typedef struct packed {
    logic jumpUp;
    logic jumpDown;
    logic step;
    logic armWait;
  } seqStrobe_t;

  localparam int SCRIPT_LEN = 23;
  localparam int UP_START   = 0;
  localparam int DOWN_START = 15;
  localparam int PTR_W      = $clog2(SCRIPT_LEN);

  localparam logic [1:0] LINE_GAIN = 2'b01;
  localparam logic [REG_W-1:0] AMP_REG = 8'h11;

  function automatic logic [REG_W-1:0] ampWord(input logic saveOn, input logic ampOn);
    return {LINE_GAIN, 3'b000, saveOn, ampOn, ampOn};
  endfunction

  function automatic step_t wr(input logic [REG_W-1:0] a, input logic [REG_W-1:0] d);
    step_t s;
    s.kind = OP_WRITE;
    s.addr = a;
    s.data = d;
    return s;
  endfunction

  function automatic step_t op(input opKind_e k);
    step_t s;
    s.kind = k;
    s.addr = '0;
    s.data = '0;
    return s;
  endfunction

  function automatic step_t scriptStep(input int idx);
    case (idx)
      0:  return wr(8'h01, 8'hF4);
      1:  return wr(AMP_REG, ampWord(1'b0, 1'b0));
      2:  return wr(8'h1D, 8'h01);
      3:  return wr(8'h15, 8'h05);
      4:  return wr(8'h0D, 8'h01);
      5:  return wr(8'h0E, 8'h01);
      6:  return wr(8'h1A, 8'h28);
      7:  return wr(8'h1B, 8'h28);
      8:  return wr(AMP_REG, ampWord(1'b1, 1'b0));
      9:  return op(OP_WAIT_LOCK);
      10: return wr(8'h00, 8'hC1);
      11: return wr(AMP_REG, ampWord(1'b1, 1'b1));
      12: return op(OP_WAIT_SETTLE);
      13: return wr(AMP_REG, ampWord(1'b0, 1'b1));
      14: return op(OP_END);
      15: return wr(AMP_REG, ampWord(1'b1, 1'b1));
      16: return wr(8'h00, 8'h01);
      17: return wr(AMP_REG, ampWord(1'b1, 1'b0));
      18: return op(OP_WAIT_SETTLE);
      19: return wr(8'h0D, 8'h00);
      20: return wr(8'h0E, 8'h00);
      21: return wr(AMP_REG, ampWord(1'b0, 1'b0));
      default: return op(OP_END);
    endcase
  endfunction

endpackage

// File: rtl/lops_dp.sv
module lops_dp
  import lops_pkg::*;
#(
  parameter int SETTLE_MS = 300,
  parameter int LOCK_MS   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             msTick,
  input  logic             seqActive,
  input  logic             wrReady,
  input  seqStrobe_t       strobe,
  output opKind_e          kind,
  output logic             waitArmed,
  output logic             waitZero,
  output logic             wrFire,
  output logic             wrValid,
  output logic [REG_W-1:0] wrAddr,
  output logic [REG_W-1:0] wrData
);

  localparam int LONGEST = (SETTLE_MS > LOCK_MS) ? SETTLE_MS : LOCK_MS;
  localparam int MAX_MS  = (LONGEST > 1) ? LONGEST : 1;
  localparam int CNT_W   = $clog2(MAX_MS + 1);

  logic [PTR_W-1:0] ptr;
  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] waitTarget;
  step_t            cur;

  assign cur     = scriptStep(int'(ptr));
  assign kind    = cur.kind;
  assign wrValid = seqActive && (cur.kind == OP_WRITE);
  assign wrAddr  = cur.addr;
  assign wrData  = cur.data;
  assign wrFire  = wrValid && wrReady;
  assign waitZero = (waitCnt == '0);

  assign waitTarget = (cur.kind == OP_WAIT_LOCK) ? CNT_W'(LOCK_MS) : CNT_W'(SETTLE_MS);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= PTR_W'(UP_START);
      waitCnt   <= '0;
      waitArmed <= 1'b0;
    end else if (strobe.jumpUp) begin
      ptr       <= PTR_W'(UP_START);
      waitArmed <= 1'b0;
    end else if (strobe.jumpDown) begin
      ptr       <= PTR_W'(DOWN_START);
      waitArmed <= 1'b0;
    end else if (strobe.step) begin
      ptr       <= ptr + 1'b1;
      waitArmed <= 1'b0;
    end else if (strobe.armWait) begin
      waitCnt   <= waitTarget;
      waitArmed <= 1'b1;
    end else if (waitArmed && msTick && !waitZero) begin
      waitCnt   <= waitCnt - 1'b1;
    end
  end

endmodule

// File: rtl/lops_ctrl.sv
module lops_ctrl
  import lops_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startReq,
  input  logic       stopReq,
  input  opKind_e    kind,
  input  logic       waitArmed,
  input  logic       waitZero,
  input  logic       wrFire,
  output seqStrobe_t strobe,
  output logic       seqActive,
  output logic       playing,
  output logic       done
);

  seqState_e state, stateNxt;
  logic      stopPend, pendNxt, doneNxt;

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    pendNxt  = stopPend;
    doneNxt  = 1'b0;
    case (state)
      S_IDLE: begin
        if (startReq) begin
          strobe.jumpUp = 1'b1;
          stateNxt      = S_UP;
        end
      end
      S_PLAY: begin
        if (stopReq || stopPend) begin
          strobe.jumpDown = 1'b1;
          pendNxt         = 1'b0;
          stateNxt        = S_DOWN;
        end
      end
      default: begin
        if (state == S_UP && stopReq) pendNxt = 1'b1;
        case (kind)
          OP_WRITE: strobe.step = wrFire;
          OP_WAIT_LOCK, OP_WAIT_SETTLE: begin
            if (!waitArmed)    strobe.armWait = 1'b1;
            else if (waitZero) strobe.step    = 1'b1;
          end
          default: begin
            doneNxt  = 1'b1;
            stateNxt = (state == S_UP) ? S_PLAY : S_IDLE;
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      stopPend <= 1'b0;
      done     <= 1'b0;
    end else begin
      state    <= stateNxt;
      stopPend <= pendNxt;
      done     <= doneNxt;
    end
  end

  assign seqActive = (state == S_UP) || (state == S_DOWN);
  assign playing   = (state == S_PLAY);

endmodule

// File: rtl/lineout_pwr_seq.sv
module lineout_pwr_seq
  import lops_pkg::*;
#(
  parameter int SETTLE_MS = 300,
  parameter int LOCK_MS   = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic       start_req,
  input  logic       stop_req,
  input  logic       wr_ready,
  output logic       wr_valid,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       busy,
  output logic       playing,
  output logic       done
);

  seqStrobe_t strobe;
  opKind_e    kind;
  logic       waitArmed, waitZero, wrFire, seqActive;

  lops_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .startReq  (start_req),
    .stopReq   (stop_req),
    .kind      (kind),
    .waitArmed (waitArmed),
    .waitZero  (waitZero),
    .wrFire    (wrFire),
    .strobe    (strobe),
    .seqActive (seqActive),
    .playing   (playing),
    .done      (done)
  );

  lops_dp #(
    .SETTLE_MS (SETTLE_MS),
    .LOCK_MS   (LOCK_MS)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .msTick    (ms_tick),
    .seqActive (seqActive),
    .wrReady   (wr_ready),
    .strobe    (strobe),
    .kind      (kind),
    .waitArmed (waitArmed),
    .waitZero  (waitZero),
    .wrFire    (wrFire),
    .wrValid   (wr_valid),
    .wrAddr    (wr_addr),
    .wrData    (wr_data)
  );

  assign busy = seqActive;

endmodule

// File: rtl/lops_chk.sv
module lops_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_req,
  input logic       stop_req,
  input logic       wr_ready,
  input logic       wr_valid,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       busy,
  input logic       playing,
  input logic       done
);

  logic [15:0] lastAcc;

  always_ff @(posedge clk) begin
    if (rst) lastAcc <= '0;
    else if (wr_valid && wr_ready) lastAcc <= {wr_addr, wr_data};
  end

  AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R5

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !wr_valid); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_PLAY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(playing && busy)); // R8

  AST_PLAY_AFTER_EXIT: assert property (@(posedge clk) disable iff (rst)
    $rose(playing) |-> (lastAcc == 16'h1143)); // R8

  AST_START_IN_PLAY: assert property (@(posedge clk) disable iff (rst)
    (playing && start_req && !stop_req) |=> playing); // R6

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!busy && !playing && !wr_valid && !done)); // R10

endmodule

bind lineout_pwr_seq lops_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_req (start_req),
  .stop_req  (stop_req),
  .wr_ready  (wr_ready),
  .wr_valid  (wr_valid),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .busy      (busy),
  .playing   (playing),
  .done      (done)
);

// File: tb/sim_lineout_pwr_seq.sv
`timescale 1ns/1ps
module sim_lineout_pwr_seq;

  localparam int SETTLE_T = 5;
  localparam int LOCK_T   = 3;
  localparam int NVEC     = 18;

  // {addr, data, minimum ticks before presentation}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h01, 8'hF4, 8'd0}, {8'h11, 8'h40, 8'd0}, {8'h1D, 8'h01, 8'd0},
    {8'h15, 8'h05, 8'd0}, {8'h0D, 8'h01, 8'd0}, {8'h0E, 8'h01, 8'd0},
    {8'h1A, 8'h28, 8'd0}, {8'h1B, 8'h28, 8'd0}, {8'h11, 8'h44, 8'd0},
    {8'h00, 8'hC1, 8'(LOCK_T)}, {8'h11, 8'h47, 8'd0}, {8'h11, 8'h43, 8'(SETTLE_T)},
    {8'h11, 8'h47, 8'd0}, {8'h00, 8'h01, 8'd0}, {8'h11, 8'h44, 8'd0},
    {8'h0D, 8'h00, 8'(SETTLE_T)}, {8'h0E, 8'h00, 8'd0}, {8'h11, 8'h40, 8'd0}
  };

  logic       clk = 1'b0;
  logic       rst, ms_tick, start_req, stop_req, wr_ready;
  logic       wr_valid, busy, playing, done;
  logic [7:0] wr_addr, wr_data;

  always #2 clk = ~clk;

  lineout_pwr_seq #(.SETTLE_MS(SETTLE_T), .LOCK_MS(LOCK_T)) u0 (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .start_req(start_req),
    .stop_req(stop_req), .wr_ready(wr_ready), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
    .playing(playing), .done(done)
  );

  int   nChecks = 0;
  int   nFails  = 0;
  bit   finished = 0;
  logic [15:0] logWr [128];
  int   logTicks [128];
  int   logCnt = 0;
  int   doneCnt = 0;
  int   playRiseAt = -1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bus sink, tick source and monitor
  initial begin : busModel
    int cyc = 0;
    int ticksSince = 0;
    bit prevStall = 0;
    bit prevPlay = 0;
    logic [15:0] prevWord = '0;
    wr_ready = 1'b0;
    ms_tick  = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      wr_ready = (cyc % 5) != 2;
      ms_tick  = (cyc % 3) == 0;
      if (prevStall && !rst)
        chk(wr_valid && {wr_addr, wr_data} == prevWord, "R5 hold during stall",
            {wr_valid, wr_addr, wr_data}, {1'b1, prevWord});
      prevStall = wr_valid && !wr_ready;
      prevWord  = {wr_addr, wr_data};
      if (done) doneCnt++;
      if (playing && !prevPlay) playRiseAt = logCnt;
      if (playing && wr_valid) chk(0, "R8 write while playing", 1, 0);
      prevPlay = playing;
      if (wr_valid && wr_ready) begin
        if (logCnt < 128) begin
          logWr[logCnt]    = {wr_addr, wr_data};
          logTicks[logCnt] = ticksSince;
          logCnt++;
        end
        ticksSince = 0;
      end else if (ms_tick && !wr_valid) begin
        ticksSince++;
      end
    end
  end

  task automatic pulseStart();
    start_req <= 1'b1;
    @(negedge clk);
    start_req <= 1'b0;
  endtask

  task automatic pulseStop();
    stop_req <= 1'b1;
    @(negedge clk);
    stop_req <= 1'b0;
  endtask

  task automatic waitPlay();
    for (int k = 0; k < 4000 && !playing; k++) @(negedge clk);
  endtask

  task automatic waitIdle();
    @(negedge clk);
    for (int k = 0; k < 4000 && (busy || playing); k++) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin : mainSeq
    int base, d0, n;
    rst <= 1'b1; start_req <= 1'b0; stop_req <= 1'b0;
    repeat (3) @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    chk({busy, playing, wr_valid, done} == 4'b0, "R10 reset state", {busy, playing, wr_valid, done}, 0);

    // stop while idle
    base = logCnt;
    pulseStop();
    repeat (30) @(negedge clk);
    chk(logCnt == base && !busy && !playing, "R6 stop idle ignored", logCnt - base, 0);

    // full session
    base = logCnt; d0 = doneCnt;
    pulseStart();
    chk(busy, "R9 busy after start", busy, 1);
    waitPlay();
    chk(logCnt - base == 12, "R8 writes before playing", logCnt - base, 12);
    chk(playRiseAt == base + 12, "R8 playing after exit write", playRiseAt - base, 12);
    chk(doneCnt == d0 + 1, "R9 done after bring-up", doneCnt - d0, 1);

    n = logCnt;
    pulseStart();
    repeat (30) @(negedge clk);
    chk(logCnt == n && playing, "R6 start while playing ignored", logCnt - n, 0);

    pulseStop();
    waitIdle();
    chk(logCnt - base == 18, "R4 teardown count", logCnt - base, 18);
    chk(doneCnt == d0 + 2, "R9 done after teardown", doneCnt - d0, 2);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      chk(logWr[base + i] == VEC[i][23:8], (i < 12) ? "R1 bring-up write" : "R4 teardown write",
          logWr[base + i], VEC[i][23:8]);
      if (VEC[i][7:0] != 0)
        chk(logTicks[base + i] >= int'(VEC[i][7:0]),
            (i == 9) ? "R3 lock wait" : ((i == 11) ? "R2 settle wait" : "R4 discharge wait"),
            logTicks[base + i], VEC[i][7:0]);
    end

    // stop latched during bring-up
    base = logCnt; d0 = doneCnt;
    pulseStart();
    repeat (4) @(negedge clk);
    pulseStop();
    waitIdle();
    chk(logCnt - base == 18, "R7 full bring-up then teardown", logCnt - base, 18);
    chk(logWr[base + 11] == 16'h1143 && logWr[base + 12] == 16'h1147, "R7 order at handover",
        logWr[base + 12], 16'h1147);
    chk(playRiseAt == base + 12, "R7 playback reached", playRiseAt - base, 12);
    chk(doneCnt == d0 + 2, "R7 two done pulses", doneCnt - d0, 2);

    // reset in mid bring-up
    base = logCnt;
    pulseStart();
    for (int k = 0; k < 2000 && logCnt < base + 5; k++) @(negedge clk);
    rst <= 1'b1;
    @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    n = logCnt;
    repeat (40) @(negedge clk);
    chk(logCnt == n && !busy && !playing && !wr_valid, "R10 reset stops script", logCnt - n, 0);

    base = logCnt;
    pulseStart();
    for (int k = 0; k < 2000 && logCnt == base; k++) @(negedge clk);
    chk(logWr[base] == 16'h01F4, "R10 restart from first write", logWr[base], 16'h01F4);
    waitPlay();
    chk(logCnt - base == 12, "R1 restarted bring-up", logCnt - base, 12);
    pulseStop();
    waitIdle();
    chk(logWr[logCnt - 1] == 16'h1140 && !busy, "R4 final write", logWr[logCnt - 1], 16'h1140);

    summary();
  end

endmodule